// File: doc/BRIEF.md
# Fixed-Point RGB to YUV Converter

This block turns a stream of 8-bit red, green and blue samples into studio-range luma and colour-difference bytes. Each cycle with the input valid flag high carries one pixel. Exactly two clocks later the matching Y, U and V bytes appear with the output valid flag high. There is no backpressure. The block accepts a new pixel on every cycle.

Each output channel forms three signed products of the input samples with fixed 13-bit fractional constants. It sums the three products, shifts the total right arithmetically by 13 and adds an offset: 16 for luma and 128 for both chroma channels. The first pipeline stage holds the three sums. The second stage holds the shifted, offset and saturated bytes. The constants are fixed in a package and cannot be programmed.

Top module: `rgb2yuv_conv`

## Requirements
- R1: The Y output equals 16 + ((2104*R + 4130*G + 802*B) >>> 13).
- R2: The U output equals 128 + ((3598*B - 1217*R - 2382*G) >>> 13).
- R3: The V output equals 128 + ((3598*R - 3015*G - 583*B) >>> 13).
- R4: The three products of a channel are summed at full precision before the one shift, with no rounding per term. White (255,255,255) gives Y = 235; truncating each term separately would give 233.
- R5: The shift is arithmetic, so a negative sum rounds toward minus infinity. Red (255,0,0) gives U = 90. White gives U = 127. Blue (0,0,255) gives V = 109.
- R6: Each result is saturated to 0..255 before it is driven. With 8-bit inputs, Y stays within 16..235 and U and V stay within 15..240.
- R7: Each pixel taken with valid_i high produces exactly one result, with valid_o high, two clocks later and in input order. Back-to-back pixels are accepted every cycle.
- R8: While rst_ni is low, valid_o is low. No pixel that was in flight before reset ever appears afterwards.
- R9: While valid_i is low, the values on r_i, g_i and b_i have no effect: no result is produced and no result already in flight changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel valid |
| r_i | input | 8 | Red sample |
| g_i | input | 8 | Green sample |
| b_i | input | 8 | Blue sample |
| valid_o | output | 1 | Output pixel valid, two clocks after valid_i |
| y_o | output | 8 | Luma |
| u_o | output | 8 | Blue colour difference |
| v_o | output | 8 | Red colour difference |

## Verification
Black, white and the three pure primaries are driven one at a time, and each result is compared against a hand-computed constant. Black fixes the offsets. White separates a single shift of the full sum from truncating each term. The primaries give negative chroma sums, which separate floor rounding from rounding toward zero. A long stream of pseudo-random pixels with random idle gaps then runs through a scoreboard against an integer model. The gaps carry random data on the colour inputs, so a block that leaks idle data would produce extra or altered results. A reset asserted while pixels are in flight shows whether the pipeline valid bits are cleared.

// File: rtl/rgb2yuv_pkg.sv
package rgb2yuv_pkg;

  localparam int unsigned NUM_CH  = 3;
  localparam int unsigned COEF_W  = 14;
  localparam int unsigned FRAC_SH = 13;

  typedef enum logic [1:0] {
    CH_Y = 2'd0,
    CH_U = 2'd1,
    CH_V = 2'd2
  } ch_e;

  typedef enum logic [1:0] {
    SRC_R = 2'd0,
    SRC_G = 2'd1,
    SRC_B = 2'd2
  } src_e;

  // signed weight of source src on channel ch, scaled by 2**13
  function automatic int coef(input int ch, input int src);
    int k;
    k = 0;
    case (ch)
      CH_Y: case (src)
        SRC_R:   k = 2104;
        SRC_G:   k = 4130;
        default: k = 802;
      endcase
      CH_U: case (src)
        SRC_R:   k = -1217;
        SRC_G:   k = -2382;
        default: k = 3598;
      endcase
      default: case (src)
        SRC_R:   k = 3598;
        SRC_G:   k = -3015;
        default: k = -583;
      endcase
    endcase
    return k;
  endfunction

  function automatic int offset(input int ch);
    return (ch == CH_Y) ? 16 : 128;
  endfunction

endpackage

// File: rtl/csc_mac.sv
module csc_mac #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 14,
  parameter int unsigned ACC_W  = 24,
  parameter int          K_R    = 0,
  parameter int          K_G    = 0,
  parameter int          K_B    = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [PIX_W-1:0]        r_i,
  input  logic [PIX_W-1:0]        g_i,
  input  logic [PIX_W-1:0]        b_i,
  output logic signed [ACC_W-1:0] acc_o
);

  localparam int unsigned PROD_W = PIX_W + COEF_W + 1;

  localparam logic signed [COEF_W-1:0] CR = COEF_W'(K_R);
  localparam logic signed [COEF_W-1:0] CG = COEF_W'(K_G);
  localparam logic signed [COEF_W-1:0] CB = COEF_W'(K_B);

  logic signed [PROD_W-1:0] p_r, p_g, p_b;
  logic signed [ACC_W-1:0]  sum;

  always_comb begin
    p_r = PROD_W'($signed({1'b0, r_i})) * PROD_W'(CR);
    p_g = PROD_W'($signed({1'b0, g_i})) * PROD_W'(CG);
    p_b = PROD_W'($signed({1'b0, b_i})) * PROD_W'(CB);
    // full-precision sum, no per-term rounding
    sum = ACC_W'(p_r) + ACC_W'(p_g) + ACC_W'(p_b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= sum;
  end

endmodule

// File: rtl/csc_norm.sv
module csc_norm #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned SHIFT  = 13,
  parameter int          OFFSET = 128
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic [PIX_W-1:0]        pix_o
);

  localparam int MAX_V = (1 << PIX_W) - 1;
  localparam logic signed [ACC_W-1:0] OFS  = ACC_W'(OFFSET);
  localparam logic signed [ACC_W-1:0] TOPV = ACC_W'(MAX_V);

  logic signed [ACC_W-1:0] shr, biased;
  logic                    sat_hi, sat_lo;
  logic [PIX_W-1:0]        nxt;

  always_comb begin
    shr    = acc_i >>> SHIFT;
    biased = shr + OFS;
    sat_hi = biased > TOPV;
    sat_lo = biased < 0;
    if (sat_hi)      nxt = '1;
    else if (sat_lo) nxt = '0;
    else             nxt = biased[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pix_o <= '0;
    else if (en_i) pix_o <= nxt;
  end

  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sat_hi) |=> (pix_o == PIX_W'(MAX_V))); // R6
  AST_SAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sat_lo) |=> (pix_o == '0)); // R6

endmodule

// File: rtl/rgb2yuv_conv.sv
module rgb2yuv_conv #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] u_o,
  output logic [PIX_W-1:0] v_o
);
  import rgb2yuv_pkg::*;

  logic                    valid_q1;
  logic signed [ACC_W-1:0] acc_q [NUM_CH];
  logic [PIX_W-1:0]        pix_q [NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q1 <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_q1 <= valid_i;
      valid_o  <= valid_q1;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    csc_mac #(
      .PIX_W (PIX_W),
      .COEF_W(COEF_W),
      .ACC_W (ACC_W),
      .K_R   (coef(ch, SRC_R)),
      .K_G   (coef(ch, SRC_G)),
      .K_B   (coef(ch, SRC_B))
    ) u_mac (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (valid_i),
      .r_i   (r_i),
      .g_i   (g_i),
      .b_i   (b_i),
      .acc_o (acc_q[ch])
    );

    csc_norm #(
      .PIX_W (PIX_W),
      .ACC_W (ACC_W),
      .SHIFT (FRAC_SH),
      .OFFSET(offset(ch))
    ) u_norm (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (valid_q1),
      .acc_i (acc_q[ch]),
      .pix_o (pix_q[ch])
    );
  end

  assign y_o = pix_q[CH_Y];
  assign u_o = pix_q[CH_U];
  assign v_o = pix_q[CH_V];

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(valid_i, 2)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o); // R8
  AST_Y_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (y_o >= PIX_W'(16) && y_o <= PIX_W'(235))); // R6
  AST_U_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (u_o >= PIX_W'(15) && u_o <= PIX_W'(240))); // R6
  AST_V_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (v_o >= PIX_W'(15) && v_o <= PIX_W'(240))); // R6

endmodule

// File: tb/tb_rgb2yuv_conv.sv
module tb_rgb2yuv_conv;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] r_i = '0, g_i = '0, b_i = '0;
  logic       valid_o;
  logic [7:0] y_o, u_o, v_o;

  typedef struct {
    int y;
    int u;
    int v;
    int due;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  bit   done   = 1'b0;

  rgb2yuv_conv dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .r_i    (r_i),
    .g_i    (g_i),
    .b_i    (b_i),
    .valid_o(valid_o),
    .y_o    (y_o),
    .u_o    (u_o),
    .v_o    (v_o)
  );

  always #2ns clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  // integer reference from the requirement formulas; clamp per R6
  function automatic int model(input int ch, input int r, input int g, input int b);
    int s, o;
    case (ch)
      0: begin s = 2104*r + 4130*g + 802*b;  o = 16;  end
      1: begin s = 3598*b - 1217*r - 2382*g; o = 128; end
      default: begin s = 3598*r - 3015*g - 583*b; o = 128; end
    endcase
    s = (s >>> 13) + o;
    if (s > 255) s = 255;
    if (s < 0)   s = 0;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int r, input int g, input int b);
    exp_t e;
    @(negedge clk_i);
    r_i = 8'(r); g_i = 8'(g); b_i = 8'(b);
    valid_i = 1'b1;
    e.y = model(0, r, g, b);
    e.u = model(1, r, g, b);
    e.v = model(2, r, g, b);
    e.due = cyc + 2;
    q.push_back(e);
  endtask

  // R9: idle cycles carry random data
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      r_i = 8'($urandom); g_i = 8'($urandom); b_i = 8'($urandom);
    end
  endtask

  task automatic direct(input int r, input int g, input int b,
                        input int ey, input int eu, input int ev, input string tag);
    send(r, g, b);
    idle(1);
    @(negedge clk_i);
    chk(valid_o == 1'b1, {tag, " valid"}, int'(valid_o), 1);
    chk(int'(y_o) == ey, {tag, " Y"}, int'(y_o), ey);
    chk(int'(u_o) == eu, {tag, " U"}, int'(u_o), eu);
    chk(int'(v_o) == ev, {tag, " V"}, int'(v_o), ev);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done && valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9 spurious output", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(y_o) == e.y, "R1 Y", int'(y_o), e.y);
        chk(int'(u_o) == e.u, "R2 U", int'(u_o), e.u);
        chk(int'(v_o) == e.v, "R3 V", int'(v_o), e.v);
        chk(cyc == e.due, "R7 latency", cyc, e.due);
        chk(y_o >= 8'd16 && y_o <= 8'd235 && u_o >= 8'd15 && u_o <= 8'd240
            && v_o >= 8'd15 && v_o <= 8'd240, "R6 band", int'(y_o), 16);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R8 reset state", int'(valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);
    chk(valid_o == 1'b0, "R8 idle after reset", int'(valid_o), 0);

    direct(0, 0, 0, 16, 128, 128, "R1 black");
    direct(255, 255, 255, 235, 127, 128, "R4 R5 white");
    direct(255, 0, 0, 81, 90, 239, "R5 red");
    direct(0, 255, 0, 144, 53, 34, "R2 R3 green");
    direct(0, 0, 255, 40, 239, 109, "R5 blue");

    // back-to-back primaries, full throughput (R7)
    send(255, 0, 0); send(0, 255, 0); send(0, 0, 255); send(255, 255, 255);
    idle(4);

    // random stream with gaps (R1, R2, R3, R9)
    for (int i = 0; i < 400; i++) begin
      send(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(4);
    chk(q.size() == 0, "R7 all results delivered", q.size(), 0);

    // reset with pixels in flight (R8)
    send(10, 20, 30); send(200, 100, 50);
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1ns;
    q.delete();
    chk(valid_o == 1'b0, "R8 reset mid-flight", int'(valid_o), 0);
    idle(2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      idle(1);
      chk(valid_o == 1'b0, "R8 no stale output", int'(valid_o), 0);
    end

    direct(128, 64, 32, model(0, 128, 64, 32), model(1, 128, 64, 32),
           model(2, 128, 64, 32), "R1 after reset");
    idle(4);
    chk(q.size() == 0, "R7 queue empty", q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule